// File: doc/BRIEF.md
# Asynchronous Serial Port with Read-Then-Clear Status Flags

This block is a byte-wide asynchronous serial port with one start bit, eight data bits sent least significant bit first, one stop bit and no parity. A host reaches it through a small register bus. The bus has a control register, a status register, a transmit holding register and a receive holding register. Both directions run from one fixed tick that sits at sixteen times the bit rate.

The status register holds five flags: transmit-empty, receive-full, framing error, a parity slot and overrun. The parity slot always reads 0 in this frame format. A flag is cleared only by a two-step handshake. The host first reads the flag as 1, then writes 0 to its bit position. A write of 0 without that earlier read does nothing, and a write of 1 never changes a flag.

Transmission starts when the transmitter is enabled and the host clears transmit-empty. Loading the shift register sets transmit-empty again. Two interrupt lines are gated by one enable bit: one reports a full receive register, the other reports any receive error.

Top module: `uart_flags_ctrl`

## Requirements
- R1: After reset:
  - control (address 0) reads 0x00.
  - status (address 1) reads 0x01, with only transmit-empty at bit 0 set.
  - both interrupt outputs are low.
  - `txd` is high.
- R2: A status flag is cleared by a write of 0 to its bit only if that flag was read as 1 at address 1 since it was last set. A write of 0 without such a read is ignored. Writing 1 to a flag bit never changes the flag. Status bit positions:
  - bit 0: transmit-empty
  - bit 1: receive-full
  - bit 2: framing error
  - bit 3: parity, always 0
  - bit 4: overrun
- R3: While the transmit enable (control bit 1) is 0, transmit-empty is held at 1, and an attempt to clear it leaves it at 1.
- R4: With transmit enable at 1, the transmitter starts only once transmit-empty has been cleared. Data written to address 2 alone starts nothing.
- R5: On start, the transmitter copies address 2 into its shift register and sets transmit-empty to 1. It then sends a frame on `txd`:
  - a 0 start bit
  - eight data bits, least significant bit first
  - a 1 stop bit
  - each bit lasts OVS baud ticks
- R6: With the receive enable (control bit 2) at 1, a low level on `rxd` starts a frame. The received byte is moved into address 3 and receive-full is set.
- R7: A start bit that is high again at its mid-bit sample, OVS/2 ticks after detection, is discarded. No flag changes.
- R8: A stop bit sampled as 0 sets the framing-error flag.
- R9: A frame that completes while receive-full is 1 sets the overrun flag, and address 3 keeps its old byte.
- R10: Clearing the receive enable leaves the receive-full, framing, parity and overrun flags unchanged, and no new frame is taken.
- R11: Control bit 0 is the interrupt enable:
  - `irq_rx_full` is high while the enable and receive-full are both 1.
  - `irq_rx_err` is high while the enable is 1 and any error flag is 1.
  - Clearing either the flag or the enable withdraws the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a status read arms the clear handshake |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 transmit, 3 receive |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the selected register (combinational) |
| rxd | input | 1 | Serial input, asynchronous |
| txd | output | 1 | Serial output, idle high |
| irq_rx_full | output | 1 | Receive-full interrupt request |
| irq_rx_err | output | 1 | Receive-error interrupt request |

## Verification
The receiver is driven from a table of bytes:
- Alternating patterns, all zeros and all ones tell a bit-order fault apart from a stuck sampling phase.
- One entry with a bad stop bit separates the framing path from the data path.

The transmitter gets bytes with a single bit set at either end. These show whether the least significant bit really goes first and whether the stop bit is inserted.

Directed cases cover the rest:
- A write of 0 made before the read, which must be ignored.
- A second frame arriving onto a full register.
- A short low pulse, which must not become a frame.
- Toggling the enables, which separates forced flag values from held flag values.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NFLAG  = 5;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_TXD  = 2'd2,
    A_RXD  = 2'd3
  } reg_addr_e;

  localparam int CB_RIE = 0;
  localparam int CB_TE  = 1;
  localparam int CB_RE  = 2;

  localparam int SB_TXE = 0;
  localparam int SB_RXF = 1;
  localparam int SB_FE  = 2;
  localparam int SB_PE  = 3;
  localparam int SB_OVR = 4;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // tick count at which the start bit is re-checked
  function automatic int unsigned mid_tick(input int unsigned ovs);
    return ovs / 2;
  endfunction

  // width of a counter that must hold values 0..n-1
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/uart_fc_tick.sv
module uart_fc_tick #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import uart_fc_pkg::*;
  localparam int unsigned CW = cnt_w(DIV);

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx #(
  parameter int unsigned DW  = 8,
  parameter int unsigned OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          te,
  input  logic          txe,
  input  logic [DW-1:0] tdr,
  output logic          load,
  output logic          txd
);
  import uart_fc_pkg::*;
  localparam int unsigned FW  = DW + 2;
  localparam int unsigned TCW = cnt_w(OVS);
  localparam int unsigned BCW = cnt_w(FW + 1);

  logic [FW-1:0]  sh;
  logic [TCW-1:0] tcnt;
  logic [BCW-1:0] bcnt;
  logic           busy;

  assign load = te && !txe && !busy;
  assign txd  = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      tcnt <= '0;
      bcnt <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= {1'b1, tdr, 1'b0};
      tcnt <= '0;
      bcnt <= '0;
      busy <= 1'b1;
    end else if (busy && tick) begin
      if (tcnt == TCW'(OVS - 1)) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[FW-1:1]};
        bcnt <= bcnt + 1'b1;
        if (bcnt == BCW'(FW - 1)) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx #(
  parameter int unsigned DW  = 8,
  parameter int unsigned OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          re,
  input  logic          rxd,
  output logic          done,
  output logic          stop_ok,
  output logic [DW-1:0] data
);
  import uart_fc_pkg::*;
  localparam int unsigned TCW  = cnt_w(OVS);
  localparam int unsigned BCW  = cnt_w(DW);
  localparam int unsigned HALF = mid_tick(OVS);

  rx_state_e      st;
  logic           s1, s2;
  logic [TCW-1:0] tcnt;
  logic [BCW-1:0] bcnt;
  logic [DW-1:0]  sh;
  logic           bit_end;

  assign bit_end = tick && (tcnt == TCW'(OVS - 1));
  assign done    = re && (st == RX_STOP) && bit_end;
  assign stop_ok = s2;
  assign data    = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      tcnt <= '0;
      bcnt <= '0;
      sh   <= '0;
    end else if (!re) begin
      st   <= RX_IDLE;
    end else if (tick) begin
      case (st)
        RX_IDLE: if (!s2) begin
          st   <= RX_START;
          tcnt <= '0;
        end
        RX_START: if (tcnt == TCW'(HALF - 1)) begin
          tcnt <= '0;
          bcnt <= '0;
          st   <= s2 ? RX_IDLE : RX_DATA;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
        RX_DATA: if (tcnt == TCW'(OVS - 1)) begin
          tcnt <= '0;
          sh   <= {s2, sh[DW-1:1]};
          bcnt <= bcnt + 1'b1;
          if (bcnt == BCW'(DW - 1)) st <= RX_STOP;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
        default: if (tcnt == TCW'(OVS - 1)) begin
          tcnt <= '0;
          st   <= RX_IDLE;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_fc_regs.sv
module uart_fc_regs #(
  parameter int unsigned DW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [1:0]                bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  output logic [DW-1:0]             bus_rdata,
  input  logic                      rx_done,
  input  logic                      rx_stop_ok,
  input  logic [DW-1:0]             rx_byte,
  input  logic                      tx_load,
  output logic [2:0]                ctrl,
  output logic [uart_fc_pkg::NFLAG-1:0] flags,
  output logic [DW-1:0]             tdr,
  output logic [DW-1:0]             rdr,
  output logic                      stat_wr
);
  import uart_fc_pkg::*;

  logic [NFLAG-1:0] arm, flags_n, arm_n;
  logic             stat_rd;

  assign stat_rd = bus_rd && (bus_addr == A_STAT);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);

  always_comb begin
    flags_n = flags;
    arm_n   = arm;
    if (stat_rd) arm_n = arm | flags;
    if (stat_wr) begin
      for (int i = 0; i < int'(NFLAG); i++) begin
        if (!bus_wdata[i] && arm[i]) begin
          flags_n[i] = 1'b0;
          arm_n[i]   = 1'b0;
        end
      end
    end
    if (tx_load || !ctrl[CB_TE]) flags_n[SB_TXE] = 1'b1;
    if (rx_done) begin
      if (flags[SB_RXF]) flags_n[SB_OVR] = 1'b1;
      else               flags_n[SB_RXF] = 1'b1;
      if (!rx_stop_ok)   flags_n[SB_FE]  = 1'b1;
    end
    flags_n[SB_PE] = 1'b0;
    arm_n = arm_n & flags_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      flags <= NFLAG'(1) << SB_TXE;
      arm   <= '0;
      tdr   <= '0;
      rdr   <= '0;
    end else begin
      flags <= flags_n;
      arm   <= arm_n;
      if (bus_wr && bus_addr == A_CTRL) ctrl <= bus_wdata[2:0];
      if (bus_wr && bus_addr == A_TXD)  tdr  <= bus_wdata;
      if (rx_done && !flags[SB_RXF])    rdr  <= rx_byte;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(DW-3){1'b0}}, ctrl};
      A_STAT:  bus_rdata = {{(DW-NFLAG){1'b0}}, flags};
      A_TXD:   bus_rdata = tdr;
      default: bus_rdata = rdr;
    endcase
  end
endmodule

// File: rtl/uart_flags_ctrl.sv
module uart_flags_ctrl #(
  parameter int unsigned DW  = 8,
  parameter int unsigned OVS = 16,
  parameter int unsigned DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rxd,
  output logic          txd,
  output logic          irq_rx_full,
  output logic          irq_rx_err
);
  import uart_fc_pkg::*;

  logic             tick;
  logic [2:0]       ctrl;
  logic [NFLAG-1:0] stat_flags;
  logic [DW-1:0]    tdr_q, rdr_q, rx_byte;
  logic             ctrl_rie, ctrl_te, ctrl_re;
  logic             rx_done, rx_stop_ok, tx_load, stat_wr;

  assign ctrl_rie = ctrl[CB_RIE];
  assign ctrl_te  = ctrl[CB_TE];
  assign ctrl_re  = ctrl[CB_RE];

  uart_fc_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  uart_fc_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_done(rx_done), .rx_stop_ok(rx_stop_ok), .rx_byte(rx_byte),
    .tx_load(tx_load), .ctrl(ctrl), .flags(stat_flags),
    .tdr(tdr_q), .rdr(rdr_q), .stat_wr(stat_wr)
  );

  uart_fc_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .te(ctrl_te),
    .txe(stat_flags[SB_TXE]), .tdr(tdr_q), .load(tx_load), .txd(txd)
  );

  uart_fc_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .re(ctrl_re), .rxd(rxd),
    .done(rx_done), .stop_ok(rx_stop_ok), .data(rx_byte)
  );

  assign irq_rx_full = ctrl_rie && stat_flags[SB_RXF];
  assign irq_rx_err  = ctrl_rie &&
                       (stat_flags[SB_FE] || stat_flags[SB_PE] || stat_flags[SB_OVR]);
endmodule

// File: rtl/uart_flags_chk.sv
module uart_flags_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_rie,
  input logic          ctrl_te,
  input logic          ctrl_re,
  input logic [4:0]    stat_flags,
  input logic          rx_done,
  input logic          rx_stop_ok,
  input logic          tx_load,
  input logic          stat_wr,
  input logic [DW-1:0] rdr_q,
  input logic          irq_rx_full,
  input logic          irq_rx_err
);
  p_txe_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_te |=> stat_flags[0]);

  p_load_sets_txe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> stat_flags[0]);

  p_clear_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_flags[1]) |-> $past(stat_wr));

  p_ovr_keeps_rdr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && stat_flags[1] |=> stat_flags[4] && $stable(rdr_q));

  p_frame_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_stop_ok |=> stat_flags[2]);

  p_re_off_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_re && !stat_wr |=> $stable(stat_flags[4:1]));

  p_full_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !stat_flags[1] && ctrl_rie |=> irq_rx_full);

  p_err_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_stop_ok && ctrl_rie |=> irq_rx_err);
endmodule

bind uart_flags_ctrl uart_flags_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_rie(ctrl_rie), .ctrl_te(ctrl_te),
  .ctrl_re(ctrl_re), .stat_flags(stat_flags), .rx_done(rx_done),
  .rx_stop_ok(rx_stop_ok), .tx_load(tx_load), .stat_wr(stat_wr),
  .rdr_q(rdr_q), .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err)
);

// File: tb/test_uart_flags_ctrl.sv
`timescale 1ns/1ps
module test_uart_flags_ctrl;
  localparam int DIV  = 2;
  localparam int OVS  = 16;
  localparam int BITC = DIV * OVS;

  localparam logic [8:0] RX_VEC [6] = '{9'h1A5, 9'h100, 9'h1FF, 9'h13C, 9'h081, 9'h15A};
  localparam logic [7:0] TX_VEC [4] = '{8'h55, 8'h01, 8'h80, 8'hC3};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic       rxd = 1'b1, txd, irq_rx_full, irq_rx_err;
  int         checks = 0, errors = 0;
  logic       done_flag = 1'b0;

  always #2 clk = ~clk;

  uart_flags_ctrl #(.DW(8), .OVS(OVS), .DIV(DIV)) i_uart_flags_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    @(negedge clk);
    rxd = 1'b0; idle(BITC);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i]; idle(BITC);
    end
    rxd = stop;
    idle(stop ? BITC : 22);
    rxd = 1'b1; idle(BITC + 20);
  endtask

  // clear receive flags through the handshake, keeping transmit-empty
  task automatic clear_rx();
    logic [7:0] s;
    rd(2'd1, s);
    wr(2'd1, 8'h01);
  endtask

  task automatic capture(output logic st, output logic [7:0] b, output logic sp);
    int n = 0;
    while (txd !== 1'b0 && n < 200) begin
      @(negedge clk); n++;
    end
    idle(BITC / 2); st = txd;
    for (int i = 0; i < 8; i++) begin
      idle(BITC); b[i] = txd;
    end
    idle(BITC); sp = txd;
    idle(BITC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic st, sp;
    logic [7:0] b;
    logic stayed;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    rd(2'd1, v); check("R1 status", v, 8'h01);
    check("R1 irqs", {irq_rx_full, irq_rx_err}, 2'b00);
    check("R1 txd", txd, 1'b1);

    // R6 R8 R11: table of received frames
    wr(2'd0, 8'h05);
    foreach (RX_VEC[k]) begin
      send(RX_VEC[k][7:0], RX_VEC[k][8]);
      rd(2'd1, v);
      check("R6/R8 status", v, RX_VEC[k][8] ? 8'h03 : 8'h07);
      check("R11 irq full", irq_rx_full, 1'b1);
      check("R11 irq err", irq_rx_err, !RX_VEC[k][8]);
      rd(2'd3, v); check("R6 data", v, RX_VEC[k][7:0]);
      wr(2'd1, 8'h01);
      rd(2'd1, v); check("R2 cleared", v, 8'h01);
      check("R11 withdrawn", {irq_rx_full, irq_rx_err}, 2'b00);
    end

    // R2 write 0 before any read is ignored; writing 1 keeps flag
    wr(2'd0, 8'h04);
    send(8'h3C, 1'b1);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R2 unarmed write ignored", v, 8'h03);
    check("R11 rie off no irq", irq_rx_full, 1'b0);
    wr(2'd1, 8'h03);
    rd(2'd1, v); check("R2 write 1 no effect", v, 8'h03);
    wr(2'd0, 8'h05);
    idle(1); check("R11 rie on irq", irq_rx_full, 1'b1);
    wr(2'd0, 8'h04);
    idle(1); check("R11 rie cleared withdraws", irq_rx_full, 1'b0);
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R2 armed clear", v, 8'h01);

    // R9 overrun
    wr(2'd0, 8'h05);
    send(8'hA1, 1'b1);
    send(8'hB2, 1'b1);
    rd(2'd1, v); check("R9 overrun status", v, 8'h13);
    rd(2'd3, v); check("R9 data kept", v, 8'hA1);
    check("R11 err irq on overrun", irq_rx_err, 1'b1);
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R9 cleared", v, 8'h01);

    // R10 receive disable keeps flags, takes no frame
    send(8'h77, 1'b1);
    wr(2'd0, 8'h01);
    rd(2'd1, v); check("R10 flags kept", v, 8'h03);
    send(8'h99, 1'b1);
    rd(2'd1, v); check("R10 no new frame", v, 8'h03);
    rd(2'd3, v); check("R10 data kept", v, 8'h77);
    clear_rx();

    // R7 start glitch rejected
    wr(2'd0, 8'h04);
    @(negedge clk); rxd = 1'b0; idle(6); rxd = 1'b1;
    idle(12 * BITC);
    rd(2'd1, v); check("R7 glitch ignored", v, 8'h01);

    // R3 transmit-empty held while transmitter disabled
    wr(2'd0, 8'h00);
    rd(2'd1, v);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R3 txe held", v, 8'h01);
    check("R3 txd idle", txd, 1'b1);

    // R4 data alone does not start a frame
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h42);
    stayed = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); if (txd !== 1'b1) stayed = 1'b0;
    end
    check("R4 no start without clear", stayed, 1'b1);

    // R4 R5: table of transmitted frames
    foreach (TX_VEC[k]) begin
      wr(2'd2, TX_VEC[k]);
      rd(2'd1, v);
      wr(2'd1, 8'h00);
      fork
        capture(st, b, sp);
        begin
          idle(4);
          rd(2'd1, v);
        end
      join
      check("R5 txe set on load", v, 8'h01);
      check("R5 start bit", st, 1'b0);
      check("R5 data lsb first", b, TX_VEC[k]);
      check("R5 stop bit", sp, 1'b1);
    end

    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule